// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Post-Divider

This block sits behind an oscillator output and divides that clock by 1, 2, 4, 8, 16, 32, 64 or 128, chosen by a 3-bit code. The code can be rewritten while the divider runs. The new ratio is applied only at a phase point where the outgoing and incoming divided clocks are both about to be low. As a result no pulse or gap on the output is shorter than half a period of the faster of the two ratios.

For ratios of 2 and above, the output comes from a free-running binary counter through a single output flop. For ratio 1, the input clock is passed through a gate whose enable changes only while the input clock is low. A power-down input freezes the counter and holds the output low, and the divider restarts from a clean low phase when power-down is released. An output-enable input is registered and presented as a separate drive-enable output for the pad, so the tristate buffer itself stays outside this block.

Top module: `pdiv_glitchless`

## Requirements
- R1: Ratio code k (0..7, binary on `ratio_sel`) gives an output period of 2^k input clock cycles in steady state; code 0 passes the input clock through.
- R2: In steady state the output high time equals the output low time for every code (2^(k-1) input cycles each for k >= 1, half an input cycle each for k = 0).
- R3: When the code changes from a to b while running, every output high or low phase lasts at least 2^min(a,b) input half-cycles.
- R4: A new code is applied only on the input clock edge at which the counter's low max(a,b) bits wrap to zero, so the first phase under the new ratio is low.
- R5: While `pwr_dn` is 1, the counter is held at zero, the output is low from the first input clock edge (ratio 1: from the next falling edge), and `running` is 0 one cycle later.
- R6: After `pwr_dn` returns to 0, the first output high pulse has the full length of 2^k input half-cycles.
- R7: `pad_oe` equals `out_en` as sampled at the previous rising input clock edge, whatever the value of `pwr_dn`.
- R8: While `rst_n` is 0 at rising edges, `clk_out`, `pad_oe` and `running` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided (oscillator output) |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 3 | Divide code k, ratio 2^k |
| out_en | input | 1 | Request to drive the output pad |
| pwr_dn | input | 1 | Power-down: stop and hold output low |
| clk_out | output | 1 | Divided clock |
| pad_oe | output | 1 | Registered drive enable for the output pad |
| running | output | 1 | Registered 1 when not powered down |

## Verification
A ratio change and a power-down or output-enable change can fall on the same input clock edge, and so can entry into power-down and a change of `out_en`. The bench changes `out_en` in the same cycle that `pwr_dn` rises and again in the same cycle that it falls. It then checks that `pad_oe` tracks `out_en` while the output stays low and `running` drops. On exit it measures the length of the first high pulse. It also sweeps all 64 ordered pairs of ratio codes, each change at a different phase, and judges every observed phase length against the faster ratio.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the post-divider.
// Assumes mask widths never exceed 32 bits.
package pdiv_pkg;
    localparam int unsigned DEF_SEL_W = 3;

    // Return a word with the n lowest bits set.
    function automatic logic [31:0] low_ones(input int unsigned n);
        if (n >= 32)
            return '1;
        return (32'd1 << n) - 32'd1;
    endfunction
endpackage

// File: rtl/pdiv_counter.sv
`timescale 1ns/1ps
// pdiv_counter: free-running binary counter whose bits are the divided clocks.
// Bit i toggles every 2^i cycles. hold forces the count to zero (power-down).
// Assumes hold is synchronous to clk_in.
module pdiv_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nx
);
    // Next count value, shared with the output stage.
    assign cnt_nx = cnt_q + CNT_W'(1);

    // Count up, or clear on reset or hold.
    always_ff @(posedge clk_in) begin
        if (!rst_n || hold)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end

    a_r5_cnt_held: assert property (@(posedge clk_in) disable iff (!rst_n)
        hold |=> (cnt_q == '0));
endmodule

// File: rtl/pdiv_ratio_ctl.sv
`timescale 1ns/1ps
// pdiv_ratio_ctl: keeps the active divide code and moves it to the requested
// code only when the low max(active,target) counter bits are all ones, so
// both divided clocks wrap to a fresh low phase together on that edge.
// During power-down the target is taken at once (output is held low then).
module pdiv_ratio_ctl #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             pd,
    input  logic [SEL_W-1:0] target,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [SEL_W-1:0] active_q,
    output logic [SEL_W-1:0] next_sel
);
    logic [SEL_W-1:0] wide_sel;
    logic [CNT_W-1:0] mask;
    logic             boundary;

    // Larger of the two codes sets the common wrap point.
    assign wide_sel = (active_q > target) ? active_q : target;
    // Bits of the counter that must all be one at the safe edge.
    assign mask     = CNT_W'(pdiv_pkg::low_ones(int'(wide_sel)));
    // Safe edge: the next increment clears all masked bits.
    assign boundary = ((cnt_q & mask) == mask);
    // Code in force after this edge.
    assign next_sel = (pd || boundary) ? target : active_q;

    // Register the code in force.
    always_ff @(posedge clk_in) begin
        if (!rst_n)
            active_q <= '0;
        else
            active_q <= next_sel;
    end

    // R4: a switch lands exactly where the shared low bits become zero.
    a_r4_switch_at_wrap: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!pd && (next_sel != active_q)) |=> ((cnt_q & $past(mask)) == '0));
endmodule

// File: rtl/pdiv_out_stage.sv
`timescale 1ns/1ps
// pdiv_out_stage: forms the output clock. Ratios >= 2 come from one flop
// loaded with the chosen counter bit of the next count. Ratio 1 gates the
// input clock with an enable that changes only on the falling edge, so the
// gate opens and closes while the input clock is low.
module pdiv_out_stage #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             pd,
    input  logic [SEL_W-1:0] active_q,
    input  logic [SEL_W-1:0] next_sel,
    input  logic [CNT_W-1:0] cnt_nx,
    output logic             clk_out
);
    logic             div_q;
    logic             pass_q;
    logic [SEL_W-1:0] bit_idx;

    // Counter bit that carries ratio 2^next_sel.
    assign bit_idx = next_sel - SEL_W'(1);

    // Divided-clock flop; low for ratio 1, reset and power-down.
    always_ff @(posedge clk_in) begin
        if (!rst_n || pd || (next_sel == '0))
            div_q <= 1'b0;
        else
            div_q <= cnt_nx[bit_idx];
    end

    // Pass-through enable, updated while the input clock is low.
    always_ff @(negedge clk_in) begin
        pass_q <= rst_n && !pd && (active_q == '0);
    end

    // Merge the two paths; at most one is ever active.
    assign clk_out = (clk_in & pass_q) | div_q;

    a_r3_paths_exclusive: assert property (@(posedge clk_in) disable iff (!rst_n)
        !(pass_q && div_q));
    a_r5_out_low_in_pd: assert property (@(posedge clk_in) disable iff (!rst_n)
        pd |=> !div_q);
endmodule

// File: rtl/pdiv_glitchless.sv
`timescale 1ns/1ps
// pdiv_glitchless: top of the power-of-two post-divider. Ties the counter,
// the ratio controller and the output stage together, and registers the
// pad drive enable and the running flag. All controls are assumed
// synchronous to clk_in.
module pdiv_glitchless #(
    parameter int unsigned SEL_W = pdiv_pkg::DEF_SEL_W
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             out_en,
    input  logic             pwr_dn,
    output logic             clk_out,
    output logic             pad_oe,
    output logic             running
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [SEL_W-1:0] active_q;
    logic [SEL_W-1:0] next_sel;

    pdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .hold   (pwr_dn),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx)
    );

    pdiv_ratio_ctl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctl (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .pd       (pwr_dn),
        .target   (ratio_sel),
        .cnt_q    (cnt_q),
        .active_q (active_q),
        .next_sel (next_sel)
    );

    pdiv_out_stage #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_out (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .pd       (pwr_dn),
        .active_q (active_q),
        .next_sel (next_sel),
        .cnt_nx   (cnt_nx),
        .clk_out  (clk_out)
    );

    // Register pad drive enable and running flag.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            pad_oe  <= 1'b0;
            running <= 1'b0;
        end else begin
            pad_oe  <= out_en;
            running <= !pwr_dn;
        end
    end

    a_r7_oe_rise: assert property (@(posedge clk_in) disable iff (!rst_n)
        out_en |=> pad_oe);
    a_r7_oe_fall: assert property (@(posedge clk_in) disable iff (!rst_n)
        !out_en |=> !pad_oe);
    a_r5_running_off: assert property (@(posedge clk_in) disable iff (!rst_n)
        pwr_dn |=> !running);
endmodule

// File: tb/pdiv_glitchless_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every ordered pair of ratio codes, measures output phase
// lengths in input half-cycles, and exercises power-down with output enable.
module pdiv_glitchless_tb;
    logic       clk_in = 1'b0;
    logic       rst_n;
    logic [2:0] ratio_sel;
    logic       out_en;
    logic       pwr_dn;
    logic       clk_out;
    logic       pad_oe;
    logic       running;

    int n_chk = 0;
    int n_err = 0;
    int min_run = 1;
    bit mon_en = 0;
    bit skip_run = 1;
    int run_len = 0;
    logic last_v = 1'b0;
    int hi_run = 0;
    int lo_run = 0;
    bit done = 0;

    always #2.5 clk_in = ~clk_in;

    pdiv_glitchless u_dut (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .out_en    (out_en),
        .pwr_dn    (pwr_dn),
        .clk_out   (clk_out),
        .pad_oe    (pad_oe),
        .running   (running)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample the output at the middle of a half-cycle and track phase lengths.
    task automatic take();
        logic v;
        v = clk_out;
        if (!mon_en) begin
            skip_run = 1;
            run_len  = 0;
            last_v   = v;
        end else if (v == last_v) begin
            run_len++;
        end else begin
            if (!skip_run) begin
                chk(run_len >= min_run, "R3 R4 phase length on change", run_len, min_run);
                if (last_v) hi_run = run_len;
                else        lo_run = run_len;
            end
            skip_run = 0;
            run_len  = 1;
            last_v   = v;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk_in);
            #1.25 take();
            #2.5  take();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk_in);
        #1;
    endtask

    task automatic steady(input int k);
        chk(hi_run + lo_run == (2 << k), "R1 period in half-cycles", hi_run + lo_run, 2 << k);
        chk(hi_run == lo_run, "R2 high equals low", hi_run, lo_run);
    endtask

    initial begin
        repeat (190000) @(posedge clk_in);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int cur;
        rst_n = 0; ratio_sel = 0; out_en = 0; pwr_dn = 0;
        step(3);
        chk(clk_out == 1'b0, "R8 clk_out in reset", clk_out, 0);
        chk(pad_oe == 1'b0, "R8 pad_oe in reset", pad_oe, 0);
        chk(running == 1'b0, "R8 running in reset", running, 0);
        rst_n = 1; out_en = 1;
        step(1);
        chk(pad_oe == 1'b1, "R7 pad_oe follows out_en", pad_oe, 1);
        chk(running == 1'b1, "R5 running after reset", running, 1);
        cur = 0;
        min_run = 1;
        mon_en = 1;
        step(300);
        steady(0);

        // All ordered pairs, change placed at varied phases.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                min_run = 1 << ((cur < a) ? cur : a);
                ratio_sel = 3'(a);
                step(512);
                steady(a);
                step((a * 5 + b * 3) % 17);
                min_run = 1 << ((a < b) ? a : b);
                ratio_sel = 3'(b);
                step(512);
                steady(b);
                cur = b;
            end
        end

        // Power-down with simultaneous output-enable changes.
        for (int t = 0; t < 3; t++) begin
            int k;
            int hi;
            bit seen;
            bit fin;
            k = (t == 0) ? 0 : ((t == 1) ? 3 : 7);
            min_run = 1 << ((cur < k) ? cur : k);
            ratio_sel = 3'(k);
            step(512);
            steady(k);
            cur = k;
            mon_en = 0;
            pwr_dn = 1; out_en = 0;
            step(1);
            chk(pad_oe == 1'b0, "R7 pad_oe with pwr_dn rise", pad_oe, 0);
            chk(running == 1'b0, "R5 running off", running, 0);
            step(1);
            for (int c = 0; c < 6; c++) begin
                @(posedge clk_in);
                #1.25 chk(clk_out == 1'b0, "R5 output low in power-down", clk_out, 0);
                #2.5  chk(clk_out == 1'b0, "R5 output low in power-down", clk_out, 0);
            end
            step(1);
            pwr_dn = 0; out_en = 1;
            hi = 0; seen = 0; fin = 0;
            for (int h = 0; h < 700 && !fin; h++) begin
                if (h % 2 == 0) begin
                    @(posedge clk_in);
                    #1.25;
                end else begin
                    #2.5;
                end
                if (clk_out) begin
                    hi++;
                    seen = 1;
                end else if (seen) begin
                    fin = 1;
                end
            end
            chk(hi == (1 << k), "R6 first pulse after power-down", hi, 1 << k);
            chk(pad_oe == 1'b1, "R7 pad_oe with pwr_dn fall", pad_oe, 1);
            chk(running == 1'b1, "R5 running back on", running, 1);
            step(1);
            mon_en = 1;
        end

        step(400);
        steady(cur);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule